// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. It sits on a simple register bus where a read or write completes in one clock. It controls a parameterised number of pins. Thirty-two pins share one register set, and each set is split into two 16-pin interrupt banks. For every pin, software chooses the direction and drives the output level through atomic set and clear words. It reads the pad level back through a two-flop synchronizer. It arms rising-edge and falling-edge detection independently, and it collects detected edges in a write-one-to-clear status word.

Each bank has one level interrupt output. The output is high while any status bit of that bank is set and the bank's bit in a global bank-enable word is 1. The last register set may be partly populated. Its missing pins read as zero and ignore writes.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every populated pin is an input (`pin_dir_in` bit = 1), `pin_out` is all zero, every status bit and every bank-enable bit is 0, and `bank_irq` is all zero.
- R2: Register set s occupies byte addresses 0x10 + 0x28*s onward, as ten 32-bit words in this order: direction (+0x00), output level (+0x04), set level (+0x08), clear level (+0x0C), input level (+0x10), arm rising (+0x14), disarm rising (+0x18), arm falling (+0x1C), disarm falling (+0x20), status (+0x24). Bit i of set s is pin 32*s+i. The bank-enable word is at 0x08, with bit b for bank b. Every other address reads 0.
- R3: The direction word is read/write. A bit value of 1 makes the pin an input and 0 makes it an output. This value appears on `pin_dir_in`.
- R4: Writing 1s to the set-level word drives those pins high. Writing 1s to the clear-level word drives them low. Zero bits leave their pins unchanged. The output-level, set-level and clear-level words all read back the output latch. Writes to the output-level word are ignored.
- R5: The input-level word returns the pad level of every pin, whether it is an input or an output, after two synchronizer flops. A level change becomes visible two clocks after the edge that first samples it, so a read right after a set-level write still returns the old level.
- R6: Writing 1s to the arm words enables rising or falling detection for those pins. Writing 1s to the disarm words disables it. All four words read back the current enable mask of their edge kind.
- R7: A status bit becomes 1 one clock after an armed edge is seen on the synchronised level. A pin with neither edge armed never sets status.
- R8: Writing 1 to a status bit clears it, and writing 0 has no effect. If an armed edge arrives in the same clock as the clear, the bit stays 1.
- R9: `bank_irq[b]` is high exactly while bank-enable bit b is 1 and any status bit of bank b is set. An even bank uses bits 15:0 of its set and an odd bank uses bits 31:16.
- R10: Bits of the last set that have no pin read as 0 and ignore writes. Bank-enable bits above the bank count read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| pin_in | input | NUM_PINS | Pad levels |
| pin_out | output | NUM_PINS | Output latch levels |
| pin_dir_in | output | NUM_PINS | 1 = pin is an input (pad driver off) |
| bank_irq | output | NUM_BANKS | Per-bank level interrupt |

## Verification
The bench builds the block with NUM_PINS = 40. This gives one full register set and a second set with only eight populated bits, so the partial-set masking and the three-bank interrupt layout can be observed. The pad is modelled as a loopback for output pins, which lets output edges raise status. With two sets, the bench can reach both halves of a full set, a bank that lives in a partial set, and an address just past the last set. The same-cycle clear-versus-edge case is driven with cycle-exact timing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int SET_BASE    = 'h10;
  localparam int SET_STRIDE  = 'h28;
  localparam int BANK_EN_OFS = 'h08;
  localparam int SET_BYTES   = 40;
  localparam int BANK_PINS   = 16;

  typedef enum logic [3:0] {
    W_DIR      = 4'd0,
    W_OUT      = 4'd1,
    W_SET      = 4'd2,
    W_CLR      = 4'd3,
    W_IN       = 4'd4,
    W_RISE_SET = 4'd5,
    W_RISE_CLR = 4'd6,
    W_FALL_SET = 4'd7,
    W_FALL_CLR = 4'd8,
    W_STAT     = 4'd9
  } word_e;

  function automatic logic [31:0] set_valid_mask(input int npins, input int s);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = ((s * 32 + i) < npins);
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_set_regs.sv
module gpio_set_regs
  import gpio_pkg::*;
#(
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  word,
  input  logic [31:0] wdata,
  input  logic [31:0] lvl,
  input  logic [31:0] rise,
  input  logic [31:0] fall,
  output logic [31:0] rdata,
  output logic [31:0] dir,
  output logic [31:0] out,
  output logic [31:0] status
);
  logic [31:0] rise_en, fall_en;
  logic [31:0] dir_n, out_n, rise_en_n, fall_en_n, status_n;
  logic [31:0] wmask, stat_clr, edge_hit;

  assign wmask = wdata & VALID;

  always_comb begin
    dir_n     = dir;
    out_n     = out;
    rise_en_n = rise_en;
    fall_en_n = fall_en;
    stat_clr  = '0;
    if (wr_en) begin
      case (word)
        W_DIR:      dir_n     = wmask;
        W_SET:      out_n     = out | wmask;
        W_CLR:      out_n     = out & ~wmask;
        W_RISE_SET: rise_en_n = rise_en | wmask;
        W_RISE_CLR: rise_en_n = rise_en & ~wmask;
        W_FALL_SET: fall_en_n = fall_en | wmask;
        W_FALL_CLR: fall_en_n = fall_en & ~wmask;
        W_STAT:     stat_clr  = wmask;
        default:    ;
      endcase
    end
    // a fresh edge wins over a same-cycle clear
    edge_hit = ((rise & rise_en) | (fall & fall_en)) & VALID;
    status_n = (status & ~stat_clr) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= VALID;
      out     <= '0;
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      dir     <= dir_n;
      out     <= out_n;
      rise_en <= rise_en_n;
      fall_en <= fall_en_n;
      status  <= status_n;
    end
  end

  always_comb begin
    case (word)
      W_DIR:                                  rdata = dir;
      W_OUT, W_SET, W_CLR:                    rdata = out;
      W_IN:                                   rdata = lvl & VALID;
      W_RISE_SET, W_RISE_CLR:                 rdata = rise_en;
      W_FALL_SET, W_FALL_CLR:                 rdata = fall_en;
      W_STAT:                                 rdata = status;
      default:                                rdata = '0;
    endcase
  end

  // R4: pins written through the set word are high afterwards
  p_set_drives_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_SET) |=> ((out & $past(wmask)) == $past(wmask)));

  // R4: pins written through the clear word are low afterwards
  p_clr_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_CLR) |=> ((out & $past(wmask)) == '0));

  // R8: zero bits of a status write never clear anything
  p_w1c_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_STAT) |=> (($past(status) & ~$past(wdata) & ~status) == '0));

  // R7: a status bit only rises on a pin that was armed
  p_stat_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 71,
  parameter int ADDR_W    = 12,
  localparam int NUM_SETS  = (NUM_PINS + 31) / 32,
  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_dir_in,
  output logic [NUM_BANKS-1:0] bank_irq
);
  localparam int PAD_W = NUM_SETS * 32;

  logic [PAD_W-1:0] pin_pad, dir_all, out_all, stat_all;
  logic [31:0]      set_rd [NUM_SETS];
  logic [NUM_SETS-1:0] set_hit;
  logic [NUM_BANKS-1:0] bank_en, bank_en_n;
  logic bank_en_hit;
  logic unused_hi;

  assign pin_pad = PAD_W'(pin_in);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam int BASE = SET_BASE + SET_STRIDE * s;
    logic [ADDR_W-1:0] offs;
    logic [31:0] lvl, rise, fall;

    assign offs       = bus_addr - ADDR_W'(BASE);
    assign set_hit[s] = bus_sel && (bus_addr >= ADDR_W'(BASE)) &&
                        (offs < ADDR_W'(SET_BYTES)) && (bus_addr[1:0] == 2'b00);

    gpio_sync_edge #(.W(32)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (pin_pad[32*s +: 32]),
      .lvl  (lvl),
      .rise (rise),
      .fall (fall)
    );

    gpio_set_regs #(.VALID(set_valid_mask(NUM_PINS, s))) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (set_hit[s] && bus_wr),
      .word  (offs[5:2]),
      .wdata (bus_wdata),
      .lvl   (lvl),
      .rise  (rise),
      .fall  (fall),
      .rdata (set_rd[s]),
      .dir   (dir_all[32*s +: 32]),
      .out   (out_all[32*s +: 32]),
      .status(stat_all[32*s +: 32])
    );
  end

  assign bank_en_hit = bus_sel && (bus_addr == ADDR_W'(BANK_EN_OFS));

  always_comb begin
    bank_en_n = bank_en;
    if (bank_en_hit && bus_wr) bank_en_n = bus_wdata[NUM_BANKS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_en <= '0;
    else        bank_en <= bank_en_n;
  end

  always_comb begin
    bus_rdata = '0;
    if (bank_en_hit) bus_rdata = 32'(bank_en);
    for (int s = 0; s < NUM_SETS; s++)
      if (set_hit[s]) bus_rdata = bus_rdata | set_rd[s];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_irq[b] = bank_en[b] & (|stat_all[BANK_PINS*b +: BANK_PINS]);
  end

  assign pin_out    = out_all[NUM_PINS-1:0];
  assign pin_dir_in = dir_all[NUM_PINS-1:0];
  assign unused_hi  = ^{dir_all, out_all, stat_all, bus_wdata};

  // R9: a disabled bank's interrupt output stays low one cycle after it was disabled
  p_bank_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en_hit && bus_wr && bus_wdata[0] == 1'b0) |=> !bank_irq[0]);
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  localparam int NP = 40;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] ext = '0;
  logic [NP-1:0] pad, pin_out, pin_dir_in;
  logic [NB-1:0] bank_irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pad = (pin_dir_in & ext) | (~pin_dir_in & pin_out);

  gpio_edge_ctrl #(.NUM_PINS(NP), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pad), .pin_out(pin_out), .pin_dir_in(pin_dir_in), .bank_irq(bank_irq)
  );

  // vector: [52] write, [51:40] addr, [39:8] data or expected, [7:0] requirement
  localparam int NV = 22;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 12'h010, 32'hFFFF_FFFF, 8'd1},  // R1 dir all inputs
    {1'b0, 12'h038, 32'h0000_00FF, 8'd10}, // R10 partial set
    {1'b0, 12'h008, 32'h0000_0000, 8'd1},  // R1 bank enable
    {1'b1, 12'h010, 32'hFFFF_0000, 8'd3},
    {1'b0, 12'h010, 32'hFFFF_0000, 8'd3},  // R3
    {1'b1, 12'h018, 32'h0000_00A5, 8'd4},
    {1'b0, 12'h014, 32'h0000_00A5, 8'd4},  // R4 set
    {1'b1, 12'h01C, 32'h0000_0005, 8'd4},
    {1'b0, 12'h018, 32'h0000_00A0, 8'd4},  // R4 clear
    {1'b1, 12'h014, 32'hFFFF_FFFF, 8'd4},
    {1'b0, 12'h01C, 32'h0000_00A0, 8'd4},  // R4 out word ignores writes
    {1'b1, 12'h040, 32'hFFFF_FFFF, 8'd10},
    {1'b0, 12'h03C, 32'h0000_00FF, 8'd10}, // R10
    {1'b1, 12'h024, 32'h00F0_000F, 8'd6},
    {1'b0, 12'h028, 32'h00F0_000F, 8'd6},  // R6
    {1'b1, 12'h028, 32'h0000_0003, 8'd6},
    {1'b0, 12'h024, 32'h00F0_000C, 8'd6},  // R6
    {1'b1, 12'h008, 32'hFFFF_FFFF, 8'd10},
    {1'b0, 12'h008, 32'h0000_0007, 8'd10}, // R10 bank enable width
    {1'b0, 12'h060, 32'h0000_0000, 8'd2},  // R2 past last set
    {1'b0, 12'h020, 32'h0000_00A0, 8'd5},  // R5 output loopback
    {1'b0, 12'h034, 32'h0000_0000, 8'd7}   // R7 edges before arming
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dir", 32'(pin_dir_in[31:0]) , 32'hFFFF_FFFF);
    chk("R1 dir hi", 32'(pin_dir_in[39:32]), 32'h0000_00FF);
    chk("R1 out", 32'(pin_out[31:0]), 32'h0);
    chk("R1 irq", 32'(bank_irq), 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][52]) wr(VEC[v][51:40], VEC[v][39:8]);
      else begin
        rd(VEC[v][51:40], d);
        chk($sformatf("R%0d vec%0d", VEC[v][7:0], v), d, VEC[v][39:8]);
      end
    end

    chk("R3 pin_dir_in", 32'(pin_dir_in[31:0]), 32'hFFFF_0000);

    // R7: armed rising edge on pin 20 (bank 1)
    ext[20] = 1'b1; idle(4);
    rd(12'h034, d); chk("R7 rise status", d, 32'h0010_0000);
    chk("R9 bank1 irq", 32'(bank_irq), 32'h2);
    // R7: unarmed pin 24 toggles without status
    ext[24] = 1'b1; idle(4);
    rd(12'h034, d); chk("R7 unarmed", d, 32'h0010_0000);
    // R6: arm falling on pin 24
    wr(12'h02C, 32'h0100_0000);
    rd(12'h030, d); chk("R6 fall mask", d, 32'h0100_0000);
    ext[24] = 1'b0; idle(4);
    rd(12'h034, d); chk("R7 fall status", d, 32'h0110_0000);
    // R8: write-one-to-clear
    wr(12'h034, 32'h0);
    rd(12'h034, d); chk("R8 zero write", d, 32'h0110_0000);
    wr(12'h034, 32'h0010_0000);
    rd(12'h034, d); chk("R8 clear one", d, 32'h0100_0000);
    // R9: bank gating
    wr(12'h008, 32'h5);
    chk("R9 gated", 32'(bank_irq), 32'h0);
    wr(12'h008, 32'h7);
    chk("R9 regated", 32'(bank_irq), 32'h2);
    // R9: even bank via output loopback on pin 2
    wr(12'h018, 32'h0000_0004); idle(4);
    rd(12'h034, d); chk("R9 even bank status", d, 32'h0100_0004);
    chk("R9 even bank irq", 32'(bank_irq), 32'h3);
    // R10: partial set arming and bank 2
    wr(12'h04C, 32'hFFFF_FFFF);
    rd(12'h050, d); chk("R10 arm mask", d, 32'h0000_00FF);
    ext[33] = 1'b1; idle(4);
    rd(12'h05C, d); chk("R10 set1 status", d, 32'h0000_0002);
    chk("R9 bank2 irq", 32'(bank_irq), 32'h7);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h05C, 32'hFFFF_FFFF);
    chk("R8 all cleared irq", 32'(bank_irq), 32'h0);

    // R5: input latency after a set-level write on pin 1
    wr(12'h018, 32'h0000_0002);
    #1 bus_sel = 1'b1; bus_addr = 12'h020;
    #0.5 chk("R5 old level", bus_rdata & 32'h2, 32'h0);
    bus_sel = 1'b0;
    idle(2);
    rd(12'h020, d); chk("R5 new level", d & 32'h2, 32'h2);

    // R8: edge and clear in the same cycle, status stays set
    ext[20] = 1'b0; idle(4);
    wr(12'h034, 32'hFFFF_FFFF);
    @(negedge clk); ext[20] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h034; bus_wdata = 32'h0010_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(12'h034, d); chk("R8 edge beats clear", d, 32'h0010_0000);

    // R2: unmapped and misaligned reads
    rd(12'h000, d); chk("R2 unmapped", d, 32'h0);
    rd(12'h012, d); chk("R2 misaligned", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule